// File: doc/BRIEF.md
# Dual-Select Static RAM Array

This block is a small word-organised static memory with a write port and a read port that are kept apart: words come in on `din` and leave on `dout`. Two select inputs of opposite sense must both be true before the array does anything, so two such blocks can share address and data lines and be told apart by a single decoded address bit. A separate output-mute input takes the read port off the bus whatever the selects say. That lets the read port and the write port be joined onto one shared data bus outside the block.

The read port has no real three-state driver. It is a data vector `dout` plus a drive-enable flag `dout_oe`. When the enable is low the data vector is held at zero, so a mux or bus model further out sees a known value. Writes are committed on the rising clock edge in any cycle where the write conditions hold. Reads come straight from the array in the same cycle (`READ_REG = 0`) or through a registered stage one cycle later (`READ_REG = 1`). The array has no reset.

Top module: `dsel_sram`

## Requirements
- R1: The block is selected only when `sel_n` is 0 and `sel` is 1. When selected with `rd_wr_n` = 0, the word on `din` is stored at `addr` on the rising clock edge.
- R2: When `sel_n` = 1 or `sel` = 0, no write takes place, whatever `rd_wr_n`, `din` and `addr` carry, and every stored word keeps its value.
- R3: When the block is deselected (`sel_n` = 1 or `sel` = 0), `dout_oe` is 0.
- R4: When `out_mute` = 1, `dout_oe` is 0, whatever the selects and `rd_wr_n` are.
- R5: When selected with `rd_wr_n` = 1 and `out_mute` = 0, `dout_oe` is 1 and `dout` carries the word stored at `addr`. This happens in the same cycle when `READ_REG` = 0, and one cycle later when `READ_REG` = 1.
- R6: During a write, `dout_oe` is 0. The write completes whether `out_mute` is 0 or 1.
- R7: Whenever `dout_oe` is 0, `dout` is all zeros.
- R8: Every one of the 2^`ADDR_W` locations is a distinct word, including the lowest (all zeros) and the highest (all ones) address.
- R9: A word written on a clock edge is returned by a read of the same address in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low reset for the read stage (not the array) |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| sel_n | input | 1 | Select, active low |
| sel | input | 1 | Select, active high |
| out_mute | input | 1 | 1 forces the read port off |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_oe | output | 1 | Read port drive enable |

## Verification
The bench builds the block with its default values: 8 address bits, 4 data bits and the same-cycle read path (`READ_REG` = 0). With these values it can fill and read back the whole 256-word array, test both end addresses, and check the read result in the same cycle as the request. The 4-bit data width keeps a distinct pattern at neighbouring addresses. Because reads need no extra cycle, a read in the cycle right after a write checks R9 exactly.

// File: rtl/dsel_sram_pkg.sv
package dsel_sram_pkg;

   // Operating mode decoded from the select, mute and direction inputs.
   typedef enum logic [1:0] {
      MD_IDLE  = 2'd0,   // deselected: nothing happens
      MD_READ  = 2'd1,   // selected, reading, port driven
      MD_WRITE = 2'd2,   // selected, storing din
      MD_MUTED = 2'd3    // selected read with the port forced off
   } dsel_mode_e;

endpackage

// File: rtl/dsel_mode_decode.sv
module dsel_mode_decode
   import dsel_sram_pkg::*;
(
   input  logic       sel_n,
   input  logic       sel,
   input  logic       out_mute,
   input  logic       rd_wr_n,
   output dsel_mode_e mode
);

   logic picked;

   assign picked = ~sel_n & sel;

   // Priority: deselect, then write (mute is a don't-care), then mute.
   always_comb begin
      if (!picked)
         mode = MD_IDLE;
      else if (!rd_wr_n)
         mode = MD_WRITE;
      else if (out_mute)
         mode = MD_MUTED;
      else
         mode = MD_READ;
   end

endmodule

// File: rtl/dsel_sram_array.sv
module dsel_sram_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   // No reset on the storage: contents are undefined until written.
   always_ff @(posedge clk) begin
      if (wr_en)
         cells[addr] <= wdata;
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/dsel_sram_rdport.sv
module dsel_sram_rdport #(
   parameter int DATA_W   = 4,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);

   generate
      if (READ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dout_oe <= 1'b0;
               dout    <= '0;
            end else begin
               dout_oe <= rd_en;
               dout    <= rd_en ? word : '0;
            end
         end
      end else begin : g_comb
         assign dout_oe = rd_en;
         assign dout    = rd_en ? word : '0;
      end
   endgenerate

   // R7: an undriven port always shows zeros.
   a_r7_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> (dout == '0));

endmodule

// File: rtl/dsel_sram.sv
module dsel_sram
   import dsel_sram_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 4,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              sel_n,
   input  logic              sel,
   input  logic              out_mute,
   input  logic              rd_wr_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         initial $error("dsel_sram: ADDR_W out of range 1..12 (depth %0d)", DEPTH);
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         initial $error("dsel_sram: DATA_W out of range 1..64");
      end
   endgenerate

   dsel_mode_e        mode;
   logic              wr_en;
   logic              rd_en;
   logic [DATA_W-1:0] word;

   dsel_mode_decode i_decode (
      .sel_n    (sel_n),
      .sel      (sel),
      .out_mute (out_mute),
      .rd_wr_n  (rd_wr_n),
      .mode     (mode)
   );

   assign wr_en = (mode == MD_WRITE);
   assign rd_en = (mode == MD_READ);

   dsel_sram_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_array (
      .clk   (clk),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (din),
      .rdata (word)
   );

   dsel_sram_rdport #(
      .DATA_W   (DATA_W),
      .READ_REG (READ_REG)
   ) i_rdport (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .word    (word),
      .dout    (dout),
      .dout_oe (dout_oe)
   );

   // Port-level checks; the registered variant lags by one cycle.
   generate
      if (READ_REG) begin : g_chk_reg
         a_r3_desel_off: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_n || !sel) |=> !dout_oe);
         a_r4_mute_off: assert property (@(posedge clk) disable iff (!rst_n)
            out_mute |=> !dout_oe);
         a_r6_write_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n && sel && !rd_wr_n) |=> !dout_oe);
         a_r5_read_on: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n && sel && rd_wr_n && !out_mute) |=> dout_oe);
      end else begin : g_chk_comb
         a_r3_desel_off: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_n || !sel) |-> !dout_oe);
         a_r4_mute_off: assert property (@(posedge clk) disable iff (!rst_n)
            out_mute |-> !dout_oe);
         a_r6_write_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n && sel && !rd_wr_n) |-> !dout_oe);
         a_r5_read_on: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n && sel && rd_wr_n && !out_mute) |-> dout_oe);
      end
   endgenerate

endmodule

// File: tb/test_dsel_sram.sv
module test_dsel_sram;

   localparam int AW = 8;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          sel_n = 1'b1;
   logic          sel = 1'b0;
   logic          out_mute = 1'b0;
   logic          rd_wr_n = 1'b1;
   logic [DW-1:0] dout;
   logic          dout_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dsel_sram #(.ADDR_W(AW), .DATA_W(DW), .READ_REG(1'b0)) i_dsel_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .sel_n(sel_n),
      .sel(sel), .out_mute(out_mute), .rd_wr_n(rd_wr_n),
      .dout(dout), .dout_oe(dout_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Drive one cycle of inputs at the falling edge, then sample before the rising edge.
   task automatic apply(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic csn, input logic cs, input logic od, input logic rw);
      @(negedge clk);
      addr = a; din = d; sel_n = csn; sel = cs; out_mute = od; rd_wr_n = rw;
      #3;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic od, input string req);
      apply(a, d, 1'b0, 1'b1, od, 1'b0);
      chk(dout_oe == 1'b0, {req, " oe low during write"}, dout_oe, 0);
      chk(dout == '0, {req, " zero data during write"}, dout, 0);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
      apply(a, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1);
      chk(dout_oe == 1'b1, {req, " oe high on read"}, dout_oe, 1);
      chk(dout == exp, {req, " read data"}, dout, exp);
   endtask

   task automatic idle();
      apply('0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_reset();
      idle();
      chk(dout_oe == 1'b0, "R3 reset idle oe", dout_oe, 0);
      chk(dout == '0, "R7 reset idle data", dout, 0);
   endtask

   task automatic t_basic();
      do_write(8'h00, 4'hA, 1'b0, "R6");
      do_read(8'h00, 4'hA, "R9 next-cycle");
      do_write(8'hFF, 4'h5, 1'b0, "R1");
      do_write(8'h3C, 4'hC, 1'b0, "R1");
      do_read(8'hFF, 4'h5, "R8 top address");
      do_read(8'h00, 4'hA, "R8 bottom address");
      do_read(8'h3C, 4'hC, "R5");
      idle();
   endtask

   task automatic t_write_muted();
      do_write(8'h10, 4'h9, 1'b1, "R6 muted");
      do_read(8'h10, 4'h9, "R6 muted write stored");
   endtask

   task automatic t_deselect();
      apply(8'h00, 4'h3, 1'b1, 1'b1, 1'b0, 1'b0);
      chk(dout_oe == 1'b0, "R3 sel_n high write", dout_oe, 0);
      apply(8'hFF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk(dout_oe == 1'b0, "R3 sel low write", dout_oe, 0);
      apply(8'h3C, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0);
      chk(dout_oe == 1'b0, "R3 both off write", dout_oe, 0);
      apply(8'h3C, 4'h1, 1'b1, 1'b1, 1'b0, 1'b1);
      chk(dout_oe == 1'b0, "R3 deselected read", dout_oe, 0);
      chk(dout == '0, "R7 deselected read data", dout, 0);
      do_read(8'h00, 4'hA, "R2 kept after sel_n=1");
      do_read(8'hFF, 4'h5, "R2 kept after sel=0");
      do_read(8'h3C, 4'hC, "R2 kept after both off");
   endtask

   task automatic t_mute();
      apply(8'h3C, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1);
      chk(dout_oe == 1'b0, "R4 muted read", dout_oe, 0);
      chk(dout == '0, "R7 muted read data", dout, 0);
      apply(8'h3C, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1);
      chk(dout_oe == 1'b0, "R4 muted deselected", dout_oe, 0);
      do_read(8'h3C, 4'hC, "R5 unmuted again");
   endtask

   task automatic t_sweep();
      for (int i = 0; i < (1 << AW); i++)
         do_write(AW'(i), DW'(i * 7 + 3), 1'(i % 2), "R8 sweep");
      for (int i = 0; i < (1 << AW); i++)
         do_read(AW'(i), DW'(i * 7 + 3), "R8 sweep");
      idle();
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_write_muted();
      t_deselect();
      t_mute();
      t_sweep();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule